// File: doc/BRIEF.md
# Interleaved Multisample Coverage Generator

This block works out which subsamples of one screen pixel lie inside one triangle. Each cycle it may take a pixel coordinate and three edge functions. An edge function has the form `A*X + B*Y + C`, where X and Y are measured in eighths of a pixel, so that `X = 8*x + sx` and `Y = 8*y + sy`. The block belongs to one of several coverage generators that share the screen in an interleaved pattern. A pixel outside this generator's share is dropped.

For a pixel that it owns, the block tests the three edge functions at a fixed set of 4, 8 or 16 subsample positions. These positions lie on an 8x8 grid inside the pixel, and every pixel uses the same ones. The result is a coverage mask. With the mask comes a flag that is set when the pixel is fully covered. It also gives the point at which colour should be evaluated: the pixel centre when the pixel is fully covered, and otherwise the mean position of the covered subsamples. Depth is always taken at the centre, (4,4) on the grid, which is the same point the block reports for a fully covered pixel.

The block is a two-stage pipeline with no backpressure. It accepts one pixel per cycle and emits a single-cycle result beat two clocks after it accepts the pixel.

Top module: `frag_cov_gen`

## Requirements
- R1: A pixel (x,y) belongs to this generator only when `(x mod NX) + NX*(y mod NY)` equals GEN_IDX. The defaults are NX=5, NY=4 and GEN_IDX=7.
- R2: For SAMPLES=N, the step is `s = 16/N`. Sample i uses pattern index `j = i*s + (i mod s)`. Its grid position is `sx = 2*(j mod 4) + ((j div 4) mod 2)` and `sy = 2*(j div 4) + ((j mod 4) mod 2)`, each from 0 to 7.
- R3: A subsample is covered when every edge value E is either greater than 0, or equal to 0 on an edge that takes ties. An edge takes ties when A>0, or when A==0 and B>0.
- R4: Bit i of `out_mask` is the coverage of sample i, placed at the position given by R2.
- R5: No beat is produced for a pixel this generator does not own, or for a pixel whose coverage mask is all zero.
- R6: `out_full` is 1 exactly when every mask bit is set. In that case `out_col_x` and `out_col_y` both equal 32, which is the centre (4.0) in unsigned fixed point with 3 integer and 3 fraction bits, in grid units.
- R7: For a partial mask, `out_col_x` is `floor(8*sum(sx)/count)` over the covered samples, and `out_col_y` is computed the same way from sy.
- R8: A pixel is accepted on each clock edge where `in_valid` is 1, with no gap needed between pixels. Its beat appears on `out_valid` two clock edges later. A pixel presented with `in_valid` low produces no beat.
- R9: A beat repeats the pixel's x and y on `out_x` and `out_y`.
- R10: While `rst_n` is low, and until the first accepted pixel after reset has passed through the pipeline, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel and edges present this cycle |
| in_x | input | PXW | Pixel column |
| in_y | input | PXW | Pixel row |
| e0_a | input | CW | Edge 0 X coefficient (signed) |
| e0_b | input | CW | Edge 0 Y coefficient (signed) |
| e0_c | input | CW | Edge 0 constant (signed) |
| e1_a | input | CW | Edge 1 X coefficient (signed) |
| e1_b | input | CW | Edge 1 Y coefficient (signed) |
| e1_c | input | CW | Edge 1 constant (signed) |
| e2_a | input | CW | Edge 2 X coefficient (signed) |
| e2_b | input | CW | Edge 2 Y coefficient (signed) |
| e2_c | input | CW | Edge 2 constant (signed) |
| out_valid | output | 1 | Result beat |
| out_x | output | PXW | Pixel column of the beat |
| out_y | output | PXW | Pixel row of the beat |
| out_mask | output | SAMPLES | Subsample coverage |
| out_full | output | 1 | All subsamples covered |
| out_col_x | output | 6 | Colour sample column, 3.3 fixed point in grid units |
| out_col_y | output | 6 | Colour sample row, 3.3 fixed point in grid units |

## Verification
The assertions assume that edge values never overflow the internal width, which holds when the coefficients stay within CW bits and the pixel coordinates within PXW bits. The stimulus therefore uses small coefficients and edge offsets of a few grid steps, even at pixel coordinates near the top of the 12-bit range. The latency and echo properties also assume that `in_valid`, `in_x` and `in_y` are defined in every cycle after reset. The bench drives them at all times and lowers `in_valid` between pixels.

// File: rtl/frag_cov_pkg.sv
package frag_cov_pkg;

    localparam int MAX_SAMPLES = 16;
    localparam int COL_W       = 6;
    localparam int CENTRE_FX   = 32;

    // pattern index for sample i out of n (spread across the 16-slot pattern)
    function automatic int pat_index(input int i, input int n);
        int step;
        step = MAX_SAMPLES / n;
        return i * step + (i % step);
    endfunction

    function automatic logic [2:0] samp_x(input int i, input int n);
        int j;
        j = pat_index(i, n);
        return 3'(2 * (j % 4) + ((j / 4) % 2));
    endfunction

    function automatic logic [2:0] samp_y(input int i, input int n);
        int j;
        j = pat_index(i, n);
        return 3'(2 * (j / 4) + ((j % 4) % 2));
    endfunction

endpackage

// File: rtl/frag_own_check.sv
module frag_own_check #(
    parameter int PXW     = 12,
    parameter int NX      = 5,
    parameter int NY      = 4,
    parameter int GEN_IDX = 7
) (
    input  logic [PXW-1:0] x,
    input  logic [PXW-1:0] y,
    output logic           owned
);

    logic [PXW-1:0] xm;
    logic [PXW-1:0] ym;
    int             slot;

    always_comb begin
        xm    = x % PXW'(NX);
        ym    = y % PXW'(NY);
        slot  = int'(xm) + NX * int'(ym);
        owned = (slot == GEN_IDX);
    end

endmodule

// File: rtl/frag_sample_test.sv
module frag_sample_test #(
    parameter int PXW = 12,
    parameter int CW  = 16,
    parameter int SX  = 0,
    parameter int SY  = 0
) (
    input  logic [PXW-1:0]        px,
    input  logic [PXW-1:0]        py,
    input  logic signed [CW-1:0]  ea [3],
    input  logic signed [CW-1:0]  eb [3],
    input  logic signed [CW-1:0]  ec [3],
    output logic                  covered
);

    localparam int         EW  = CW + PXW + 5;
    localparam logic [2:0] SXV = 3'(SX);
    localparam logic [2:0] SYV = 3'(SY);

    logic signed [EW-1:0] gx;
    logic signed [EW-1:0] gy;
    logic signed [EW-1:0] val [3];
    logic signed [EW-1:0] ka, kb, kc;
    logic [2:0]           pass;
    logic                 tie_ok;

    always_comb begin
        gx = $signed({{(EW-PXW-3){1'b0}}, px, SXV});
        gy = $signed({{(EW-PXW-3){1'b0}}, py, SYV});
        for (int k = 0; k < 3; k++) begin
            ka     = $signed({{(EW-CW){ea[k][CW-1]}}, ea[k]});
            kb     = $signed({{(EW-CW){eb[k][CW-1]}}, eb[k]});
            kc     = $signed({{(EW-CW){ec[k][CW-1]}}, ec[k]});
            val[k] = ka * gx + kb * gy + kc;
            // ties belong to edges with A>0, or A==0 and B>0
            tie_ok  = (ea[k] > 0) || ((ea[k] == 0) && (eb[k] > 0));
            pass[k] = (val[k] > 0) || ((val[k] == 0) && tie_ok);
        end
        covered = &pass;
    end

endmodule

// File: rtl/frag_centroid.sv
module frag_centroid #(
    parameter int NS = 16
) (
    input  logic [NS-1:0] mask,
    output logic          full,
    output logic [5:0]    col_x,
    output logic [5:0]    col_y
);
    import frag_cov_pkg::*;

    localparam int SUMW = $clog2(7 * NS + 1) + 4;

    logic [SUMW-1:0] sum_x, sum_y, cnt;

    function automatic logic [SUMW-1:0] udiv(input logic [SUMW-1:0] num,
                                             input logic [SUMW-1:0] den);
        logic [SUMW-1:0] q;
        logic [SUMW-1:0] r;
        q = '0;
        r = '0;
        for (int k = SUMW - 1; k >= 0; k--) begin
            r = {r[SUMW-2:0], num[k]};
            if (r >= den) begin
                r    = r - den;
                q[k] = 1'b1;
            end
        end
        return q;
    endfunction

    always_comb begin
        sum_x = '0;
        sum_y = '0;
        cnt   = '0;
        for (int i = 0; i < NS; i++) begin
            if (mask[i]) begin
                sum_x = sum_x + SUMW'(samp_x(i, NS));
                sum_y = sum_y + SUMW'(samp_y(i, NS));
                cnt   = cnt + SUMW'(1);
            end
        end
        full = &mask;
        if (full) begin
            col_x = 6'(CENTRE_FX);
            col_y = 6'(CENTRE_FX);
        end else if (cnt != '0) begin
            col_x = 6'(udiv(sum_x << 3, cnt));
            col_y = 6'(udiv(sum_y << 3, cnt));
        end else begin
            col_x = '0;
            col_y = '0;
        end
    end

endmodule

// File: rtl/frag_cov_gen.sv
module frag_cov_gen #(
    parameter int PXW     = 12,
    parameter int CW      = 16,
    parameter int SAMPLES = 16,
    parameter int NX      = 5,
    parameter int NY      = 4,
    parameter int GEN_IDX = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [PXW-1:0]       in_x,
    input  logic [PXW-1:0]       in_y,
    input  logic signed [CW-1:0] e0_a,
    input  logic signed [CW-1:0] e0_b,
    input  logic signed [CW-1:0] e0_c,
    input  logic signed [CW-1:0] e1_a,
    input  logic signed [CW-1:0] e1_b,
    input  logic signed [CW-1:0] e1_c,
    input  logic signed [CW-1:0] e2_a,
    input  logic signed [CW-1:0] e2_b,
    input  logic signed [CW-1:0] e2_c,
    output logic                 out_valid,
    output logic [PXW-1:0]       out_x,
    output logic [PXW-1:0]       out_y,
    output logic [SAMPLES-1:0]   out_mask,
    output logic                 out_full,
    output logic [5:0]           out_col_x,
    output logic [5:0]           out_col_y
);
    import frag_cov_pkg::*;

    typedef struct packed {
        logic               s1_vld;
        logic [PXW-1:0]     s1_x;
        logic [PXW-1:0]     s1_y;
        logic [SAMPLES-1:0] s1_mask;
        logic               o_vld;
        logic [PXW-1:0]     o_x;
        logic [PXW-1:0]     o_y;
        logic [SAMPLES-1:0] o_mask;
        logic               o_full;
        logic [5:0]         o_cx;
        logic [5:0]         o_cy;
    } pipe_t;

    pipe_t st_d, st_q;

    logic signed [CW-1:0] ea [3];
    logic signed [CW-1:0] eb [3];
    logic signed [CW-1:0] ec [3];
    logic                 owned;
    logic [SAMPLES-1:0]   cov_mask;
    logic                 cen_full;
    logic [5:0]           cen_x, cen_y;

    assign ea[0] = e0_a;  assign eb[0] = e0_b;  assign ec[0] = e0_c;
    assign ea[1] = e1_a;  assign eb[1] = e1_b;  assign ec[1] = e1_c;
    assign ea[2] = e2_a;  assign eb[2] = e2_b;  assign ec[2] = e2_c;

    frag_own_check #(
        .PXW(PXW), .NX(NX), .NY(NY), .GEN_IDX(GEN_IDX)
    ) u_own (
        .x(in_x), .y(in_y), .owned(owned)
    );

    for (genvar s = 0; s < SAMPLES; s++) begin : g_smp
        frag_sample_test #(
            .PXW(PXW), .CW(CW),
            .SX(int'(samp_x(s, SAMPLES))),
            .SY(int'(samp_y(s, SAMPLES)))
        ) u_st (
            .px(in_x), .py(in_y),
            .ea(ea), .eb(eb), .ec(ec),
            .covered(cov_mask[s])
        );
    end

    frag_centroid #(.NS(SAMPLES)) u_cen (
        .mask(st_q.s1_mask), .full(cen_full), .col_x(cen_x), .col_y(cen_y)
    );

    always_comb begin
        st_d         = st_q;
        // stage 1: filter by ownership and empty coverage
        st_d.s1_vld  = in_valid && owned && (|cov_mask);
        st_d.s1_x    = in_x;
        st_d.s1_y    = in_y;
        st_d.s1_mask = cov_mask;
        // stage 2: full flag and colour location
        st_d.o_vld   = st_q.s1_vld;
        st_d.o_x     = st_q.s1_x;
        st_d.o_y     = st_q.s1_y;
        st_d.o_mask  = st_q.s1_mask;
        st_d.o_full  = cen_full;
        st_d.o_cx    = cen_x;
        st_d.o_cy    = cen_y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.o_vld;
    assign out_x     = st_q.o_x;
    assign out_y     = st_q.o_y;
    assign out_mask  = st_q.o_mask;
    assign out_full  = st_q.o_full;
    assign out_col_x = st_q.o_cx;
    assign out_col_y = st_q.o_cy;

    AST_BEAT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_x % PXW'(NX)) + NX * int'(out_y % PXW'(NY))) == GEN_IDX); // R1
    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (|out_mask)); // R5
    AST_FULL_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_full == (&out_mask))); // R6
    AST_FULL_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_full) |-> (out_col_x == 6'd32 && out_col_y == 6'd32)); // R6
    AST_CENTROID_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_full) |-> (out_col_x <= 6'd56 && out_col_y <= 6'd56)); // R7
    AST_BEAT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R8
    AST_ECHO_COORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_x == $past(in_x, 2) && out_y == $past(in_y, 2))); // R9

endmodule

// File: tb/test_frag_cov_gen.sv
`timescale 1ns/1ps
module test_frag_cov_gen;

    localparam int PXW = 12;
    localparam int CW  = 16;
    localparam int NV  = 11;

    // x, y, expected beat, then a0 b0 c0 a1 b1 c1 a2 b2 c2
    localparam int VTAB [NV][12] = '{
        '{2,    1,    1,  0, 0,    1,  0, 0,   1,  0, 0,  1},  // full
        '{2,    1,    1,  1, 0,  -20,  0, 0,   1,  0, 0,  1},  // sx>=4 (tie taken)
        '{2,    1,    1, -1, 0,   20,  0, 0,   1,  0, 0,  1},  // sx<=3 (tie refused)
        '{2,    1,    1,  0, 1,  -12,  0, 0,   1,  0, 0,  1},  // sy>=4 (A=0,B>0 tie)
        '{2,    1,    1,  0,-1,   12,  0, 0,   1,  0, 0,  1},  // sy<=3 (A=0,B<0 refused)
        '{2,    1,    1,  1, 0,  -23,  0, 1, -15,  0, 0,  1},  // single sample at (7,7)
        '{2,    1,    0,  0, 0,   -1,  0, 0,   1,  0, 0,  1},  // empty mask
        '{3,    1,    0,  0, 0,    1,  0, 0,   1,  0, 0,  1},  // not owned
        '{7,    5,    1,  1, 1, -103,  0, 0,   1,  0, 0,  1},  // diagonal sx+sy>=7
        '{4092, 4093, 1,  0, 0,    1,  0, 0,   1,  0, 0,  1},  // far corner, full
        '{2,    1,    1,  1, 0,  -18, -1, 0,  21,  0, 1, -9}   // three real edges
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [PXW-1:0] in_x = '0, in_y = '0;
    logic signed [CW-1:0] co [9];

    logic           o_valid, o_full, p_valid, p_full;
    logic [PXW-1:0] o_x, o_y, p_x, p_y;
    logic [15:0]    o_mask;
    logic [3:0]     p_mask;
    logic [5:0]     o_cx, o_cy, p_cx, p_cy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    initial for (int k = 0; k < 9; k++) co[k] = '0;

    frag_cov_gen #(.PXW(PXW), .CW(CW), .SAMPLES(16), .GEN_IDX(7)) i_frag_cov_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .e0_a(co[0]), .e0_b(co[1]), .e0_c(co[2]),
        .e1_a(co[3]), .e1_b(co[4]), .e1_c(co[5]),
        .e2_a(co[6]), .e2_b(co[7]), .e2_c(co[8]),
        .out_valid(o_valid), .out_x(o_x), .out_y(o_y), .out_mask(o_mask),
        .out_full(o_full), .out_col_x(o_cx), .out_col_y(o_cy)
    );

    frag_cov_gen #(.PXW(PXW), .CW(CW), .SAMPLES(4), .GEN_IDX(0)) i_frag_cov_gen_s4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .e0_a(co[0]), .e0_b(co[1]), .e0_c(co[2]),
        .e1_a(co[3]), .e1_b(co[4]), .e1_c(co[5]),
        .e2_a(co[6]), .e2_b(co[7]), .e2_c(co[8]),
        .out_valid(p_valid), .out_x(p_x), .out_y(p_y), .out_mask(p_mask),
        .out_full(p_full), .out_col_x(p_cx), .out_col_y(p_cy)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // grid position from the sample pattern rule
    function automatic int pos_x(input int i, input int n);
        int st, j;
        st = 16 / n; j = i * st + (i % st);
        return 2 * (j % 4) + ((j / 4) % 2);
    endfunction
    function automatic int pos_y(input int i, input int n);
        int st, j;
        st = 16 / n; j = i * st + (i % st);
        return 2 * (j / 4) + ((j % 4) % 2);
    endfunction

    function automatic int exp_mask(input int n, input int px, input int py, input int c [9]);
        int m;
        m = 0;
        for (int i = 0; i < n; i++) begin
            bit inside_all;
            inside_all = 1'b1;
            for (int e = 0; e < 3; e++) begin
                longint v;
                bit tie;
                v = longint'(c[3*e]) * (8 * px + pos_x(i, n))
                  + longint'(c[3*e+1]) * (8 * py + pos_y(i, n)) + c[3*e+2];
                tie = (c[3*e] > 0) || (c[3*e] == 0 && c[3*e+1] > 0);
                if (!(v > 0 || (v == 0 && tie))) inside_all = 1'b0;
            end
            if (inside_all) m |= (1 << i);
        end
        return m;
    endfunction

    function automatic int exp_col(input int n, input int m, input bit use_y);
        int s, c;
        if (m == (1 << n) - 1) return 32;
        s = 0; c = 0;
        for (int i = 0; i < n; i++)
            if (m[i]) begin
                s += use_y ? pos_y(i, n) : pos_x(i, n);
                c++;
            end
        return (c == 0) ? 0 : (8 * s) / c;
    endfunction

    task automatic drive(input int px, input int py, input int c [9], input bit v);
        in_x = PXW'(px);
        in_y = PXW'(py);
        for (int k = 0; k < 9; k++) co[k] = CW'(c[k]);
        in_valid = v;
    endtask

    task automatic check_main(input int px, input int py, input int c [9], input bit beat);
        int m;
        m = exp_mask(16, px, py, c);
        chk("R1/R5 beat", o_valid, beat);
        if (beat && o_valid) begin
            chk("R3/R4 mask", o_mask, m);
            chk("R6 full", o_full, (m == 16'hFFFF));
            chk((m == 16'hFFFF) ? "R6 col_x" : "R7 col_x", o_cx, exp_col(16, m, 0));
            chk((m == 16'hFFFF) ? "R6 col_y" : "R7 col_y", o_cy, exp_col(16, m, 1));
            chk("R9 x", o_x, px);
            chk("R9 y", o_y, py);
        end
    endtask

    initial begin
        int cv [9];
        int cfull [9];
        cfull = '{0, 0, 1, 0, 0, 1, 0, 0, 1};

        // R10: owned full pixel offered during reset gives nothing
        drive(2, 1, cfull, 1'b1);
        repeat (4) @(negedge clk);
        chk("R10 in reset", o_valid, 0);
        drive(2, 1, cfull, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", o_valid, 0);
        chk("R10 after reset s4", p_valid, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 9; k++) cv[k] = VTAB[v][3 + k];
            drive(VTAB[v][0], VTAB[v][1], cv, 1'b1);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check_main(VTAB[v][0], VTAB[v][1], cv, VTAB[v][2] != 0);
        end

        // R8: in_valid low means no beat
        drive(2, 1, cfull, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 idle no beat", o_valid, 0);

        // R8: back-to-back pixels
        cv = '{1, 0, -20, 0, 0, 1, 0, 0, 1};
        drive(2, 1, cv, 1'b1);
        @(negedge clk);
        cv = '{-1, 0, 60, 0, 0, 1, 0, 0, 1};      // pixel (7,1): sx<=3
        drive(7, 1, cv, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        cv = '{1, 0, -20, 0, 0, 1, 0, 0, 1};
        chk("R8 first beat", o_valid, 1);
        chk("R8 first mask", o_mask, exp_mask(16, 2, 1, cv));
        @(negedge clk);
        cv = '{-1, 0, 60, 0, 0, 1, 0, 0, 1};
        chk("R8 second beat", o_valid, 1);
        chk("R8 second mask", o_mask, exp_mask(16, 7, 1, cv));
        chk("R8 second x", o_x, 7);
        @(negedge clk);
        chk("R8 pipe drains", o_valid, 0);

        // R2: four-sample instance, pixel (5,4) owned by index 0, sx>=4
        cv = '{1, 0, -44, 0, 0, 1, 0, 0, 1};
        drive(5, 4, cv, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 s4 beat", p_valid, 1);
        chk("R2 s4 mask", p_mask, exp_mask(4, 5, 4, cv));
        chk("R2 s4 mask literal", p_mask, 4'b1100);
        chk("R7 s4 col_x", p_cx, 44);
        chk("R7 s4 col_y", p_cy, 44);
        chk("R1 s16 drops (5,4)", o_valid, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule